// File: doc/BRIEF.md
# Least-Recently-Granted Bus Arbiter

This block shares one bus among five masters: the controller's own master port (the host) and up to four external devices. It keeps an ordered priority list of all masters, host included. When a granted transfer starts, the master being served moves to the lowest place in the list. Every other master keeps its relative place. A master that has just used the bus therefore waits behind everyone who has not.

External devices request with active-low inputs and receive active-low grants. The host uses an active-high request and grant pair. If no master requests, the bus is parked on the host. A device position with no device fitted has its request pin tied high, and it is never granted. A mode input turns arbitration off when the controller is not the bus host. In that mode every grant is released and the priority list is frozen.

The block re-evaluates the grant only when the bus is idle or when the current owner withdraws its request. A handover from one master to another always leaves a clock with no grant asserted between the two owners.

Top module: `lrg_bus_arb`

## Requirements
- R1: Under reset, `host_gnt_o` is 0 and every bit of `dev_gnt_n_o` is 1. The list leaves reset ordered host, device 1, device 2, device 3, device 4, from highest priority to lowest.
- R2: Bit i of `dev_req_n_i` is the active-low request of device i+1, and bit i of `dev_gnt_n_o` is its active-low grant. A new grant goes to the highest-placed master in the list whose request is active. Grants are registered, so they appear one clock after the inputs that cause them.
- R3: A transfer starts when `bus_frame_n_i` is low after being high on the previous clock while a grant is held in host mode. At that point the granted master moves to the lowest place in the list, and the remaining masters keep their relative order.
- R4: In host mode, when no master requests and no grant is held, the host is granted (parked) on the next clock. It stays granted while nobody else requests.
- R5: At most one grant, counting the host grant and all device grants, is asserted in any cycle.
- R6: While the bus is busy (`bus_frame_n_i` or `bus_irdy_n_i` low) and the current owner still requests, the grant does not change.
- R7: When the selected winner differs from the current owner, all grants are removed for one clock before the winner is granted.
- R8: With `host_mode_i` low, all grants are deasserted on the next clock, and the list does not change whatever the bus does.
- R9: The list is always a permutation of the five masters.
- R10: A device whose request input is held high is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode_i | input | 1 | 1: this block arbitrates the bus; 0: arbitration off |
| bus_frame_n_i | input | 1 | Bus cycle-frame signal, active low |
| bus_irdy_n_i | input | 1 | Bus initiator-ready signal, active low |
| host_req_i | input | 1 | Host master request, active high |
| host_gnt_o | output | 1 | Host master grant, active high |
| dev_req_n_i | input | NUM_EXT | External device requests, active low |
| dev_gnt_n_o | output | NUM_EXT | External device grants, active low |

## Verification
The bench builds the block with `NUM_EXT` at its default of 4, so the list holds five entries in three-bit slots. With four devices, every list position and every move-to-tail distance, from the head to the second-to-last slot, can be reached. For part of the random run the fourth device's request is held high, which covers the partly populated case on the same build. A reference list model in the bench follows the grant sequence cycle by cycle. It covers random request patterns, idle stretches in which nobody requests, and excursions into non-host mode.

// File: rtl/lrg_arb_pkg.sv
package lrg_arb_pkg;

   // Index of the host master inside the request/grant vectors and the list.
   localparam int unsigned LRG_HOST_IDX = 0;

   // Upper bound on external devices accepted by the parameter checks.
   localparam int unsigned LRG_EXT_MAX  = 7;

   // Bits needed to hold a master index for a given master count.
   function automatic int unsigned lrg_idx_bits(input int unsigned n_masters);
      int unsigned b;
      b = 1;
      while ((1 << b) < n_masters) b++;
      return b;
   endfunction

endpackage

// File: rtl/lrg_prio_list.sv
module lrg_prio_list #(
   parameter int unsigned NUM_M = 5,
   parameter int unsigned IDX_W = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_i,
   input  logic [IDX_W-1:0]         served_i,
   output logic [NUM_M*IDX_W-1:0]   list_o
);

   logic [IDX_W-1:0] slot_q   [NUM_M];
   logic [IDX_W-1:0] slot_nxt [NUM_M];
   logic [NUM_M-1:0] hit;
   logic [NUM_M-1:0] at_or_after;

   if (NUM_M < 2) begin : g_bad_count
      $error("lrg_prio_list: NUM_M must be at least 2");
   end
   if ((1 << IDX_W) < NUM_M) begin : g_bad_width
      $error("lrg_prio_list: IDX_W too narrow for NUM_M");
   end

   // Locate the served master and mark every slot from its position down.
   for (genvar k = 0; k < NUM_M; k++) begin : g_scan
      assign hit[k] = (slot_q[k] == served_i);
      if (k == 0) begin : g_first
         assign at_or_after[k] = hit[k];
      end else begin : g_rest
         assign at_or_after[k] = at_or_after[k-1] | hit[k];
      end
   end

   // Slots at or below the served one shift up by one; served goes last.
   for (genvar k = 0; k < NUM_M; k++) begin : g_next
      if (k == NUM_M - 1) begin : g_tail
         assign slot_nxt[k] = served_i;
      end else begin : g_body
         assign slot_nxt[k] = at_or_after[k] ? slot_q[k+1] : slot_q[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_M; k++) slot_q[k] <= IDX_W'(k);
      end else if (upd_i) begin
         for (int k = 0; k < NUM_M; k++) slot_q[k] <= slot_nxt[k];
      end
   end

   for (genvar k = 0; k < NUM_M; k++) begin : g_flat
      assign list_o[k*IDX_W +: IDX_W] = slot_q[k];
   end

   // Which master indices appear somewhere in the list.
   logic [NUM_M-1:0] present;
   always_comb begin
      present = '0;
      for (int m = 0; m < NUM_M; m++) begin
         for (int k = 0; k < NUM_M; k++) begin
            if (slot_q[k] == IDX_W'(m)) present[m] = 1'b1;
         end
      end
   end

   AST_LIST_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(present) == NUM_M); // R9

   AST_SERVED_TO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> slot_q[NUM_M-1] == $past(served_i)); // R3

   AST_LIST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> $stable(list_o)); // R8

endmodule

// File: rtl/lrg_pick.sv
module lrg_pick
   import lrg_arb_pkg::*;
#(
   parameter int unsigned NUM_M = 5,
   parameter int unsigned IDX_W = 3
) (
   input  logic [NUM_M*IDX_W-1:0] list_i,
   input  logic [NUM_M-1:0]       req_i,
   output logic [IDX_W-1:0]       win_idx_o,
   output logic                   any_o
);

   logic [IDX_W-1:0] slot     [NUM_M];
   logic [NUM_M-1:0] slot_req;

   for (genvar k = 0; k < NUM_M; k++) begin : g_slot
      assign slot[k]     = list_i[k*IDX_W +: IDX_W];
      assign slot_req[k] = req_i[slot[k]];
   end

   assign any_o = |req_i;

   // Highest-placed requesting slot wins; with no request the host is chosen.
   always_comb begin
      win_idx_o = IDX_W'(LRG_HOST_IDX);
      for (int k = NUM_M - 1; k >= 0; k--) begin
         if (slot_req[k]) win_idx_o = slot[k];
      end
   end

endmodule

// File: rtl/lrg_grant_ctl.sv
module lrg_grant_ctl #(
   parameter int unsigned NUM_M = 5,
   parameter int unsigned IDX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mode_i,
   input  logic              bus_idle_i,
   input  logic [NUM_M-1:0]  req_i,
   input  logic [IDX_W-1:0]  win_idx_i,
   output logic [NUM_M-1:0]  gnt_o,
   output logic [IDX_W-1:0]  owner_idx_o,
   output logic              owner_vld_o
);

   localparam logic [NUM_M-1:0] ONE = {{(NUM_M-1){1'b0}}, 1'b1};

   logic [NUM_M-1:0] gnt_q;
   logic [NUM_M-1:0] gnt_nxt;
   logic [NUM_M-1:0] win_oh;
   logic             owner_req;
   logic             reeval;

   if (NUM_M < 2) begin : g_bad_count
      $error("lrg_grant_ctl: NUM_M must be at least 2");
   end

   assign win_oh    = ONE << win_idx_i;
   assign owner_req = |(gnt_q & req_i);
   assign reeval    = bus_idle_i | ~owner_req;

   always_comb begin
      gnt_nxt = gnt_q;
      if (!host_mode_i) begin
         gnt_nxt = '0;
      end else if (reeval) begin
         if (gnt_q == '0)         gnt_nxt = win_oh;
         else if (gnt_q != win_oh) gnt_nxt = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gnt_q <= '0;
      else        gnt_q <= gnt_nxt;
   end

   always_comb begin
      owner_idx_o = '0;
      for (int m = 0; m < NUM_M; m++) begin
         if (gnt_q[m]) owner_idx_o = IDX_W'(m);
      end
   end

   assign owner_vld_o = |gnt_q;
   assign gnt_o       = gnt_q;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q)); // R5

   AST_HANDOVER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q != '0) |=> (gnt_q == '0) || $stable(gnt_q)); // R7

   AST_NONHOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !host_mode_i |=> gnt_q == '0); // R8

   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (host_mode_i && !bus_idle_i && owner_req) |=> $stable(gnt_q)); // R6

endmodule

// File: rtl/lrg_bus_arb.sv
module lrg_bus_arb
   import lrg_arb_pkg::*;
#(
   parameter int unsigned NUM_EXT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_mode_i,
   input  logic               bus_frame_n_i,
   input  logic               bus_irdy_n_i,
   input  logic               host_req_i,
   output logic               host_gnt_o,
   input  logic [NUM_EXT-1:0] dev_req_n_i,
   output logic [NUM_EXT-1:0] dev_gnt_n_o
);

   localparam int unsigned NUM_M = NUM_EXT + 1;
   localparam int unsigned IDX_W = lrg_idx_bits(NUM_M);

   if (NUM_EXT < 1 || NUM_EXT > LRG_EXT_MAX) begin : g_bad_ext
      $error("lrg_bus_arb: NUM_EXT out of supported range");
   end

   logic [NUM_M-1:0]       req;
   logic [NUM_M-1:0]       gnt;
   logic [NUM_M*IDX_W-1:0] list;
   logic [IDX_W-1:0]       win_idx;
   logic                   any_req;
   logic [IDX_W-1:0]       owner_idx;
   logic                   owner_vld;
   logic                   frame_prev_q;
   logic                   bus_idle;
   logic                   xfer_start;

   // Active-high request vector: host in slot 0, devices follow.
   assign req[LRG_HOST_IDX] = host_req_i;
   for (genvar i = 0; i < NUM_EXT; i++) begin : g_dev
      assign req[i+1]        = ~dev_req_n_i[i];
      assign dev_gnt_n_o[i]  = ~gnt[i+1];
   end
   assign host_gnt_o = gnt[LRG_HOST_IDX];

   assign bus_idle = bus_frame_n_i & bus_irdy_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frame_prev_q <= 1'b1;
      else        frame_prev_q <= bus_frame_n_i;
   end

   assign xfer_start = host_mode_i & owner_vld & frame_prev_q & ~bus_frame_n_i;

   lrg_prio_list #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_list (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_i    (xfer_start),
      .served_i (owner_idx),
      .list_o   (list)
   );

   lrg_pick #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_pick (
      .list_i    (list),
      .req_i     (req),
      .win_idx_o (win_idx),
      .any_o     (any_req)
   );

   lrg_grant_ctl #(.NUM_M(NUM_M), .IDX_W(IDX_W)) u_gnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_mode_i (host_mode_i),
      .bus_idle_i  (bus_idle),
      .req_i       (req),
      .win_idx_i   (win_idx),
      .gnt_o       (gnt),
      .owner_idx_o (owner_idx),
      .owner_vld_o (owner_vld)
   );

   AST_PARK_ON_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (host_mode_i && !any_req && gnt == '0) |=> gnt[LRG_HOST_IDX]); // R4

   AST_NO_IDLE_DEVICE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0) |=> (gnt == '0) || |(gnt & $past(req)) || gnt[LRG_HOST_IDX]); // R10

endmodule

// File: tb/lrg_bus_arb_test.sv
module lrg_bus_arb_test;

   localparam int NUM_EXT = 4;
   localparam int NUM_M   = NUM_EXT + 1;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               host_mode;
   logic               frame_n;
   logic               irdy_n;
   logic               host_req;
   logic               host_gnt;
   logic [NUM_EXT-1:0] dev_req_n;
   logic [NUM_EXT-1:0] dev_gnt_n;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   lrg_bus_arb #(.NUM_EXT(NUM_EXT)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .host_mode_i   (host_mode),
      .bus_frame_n_i (frame_n),
      .bus_irdy_n_i  (irdy_n),
      .host_req_i    (host_req),
      .host_gnt_o    (host_gnt),
      .dev_req_n_i   (dev_req_n),
      .dev_gnt_n_o   (dev_gnt_n)
   );

   // Reference list model.
   int   m_list [NUM_M];
   int   m_own;
   logic m_prev;

   function automatic logic [NUM_M-1:0] got_gnt();
      return {~dev_gnt_n, host_gnt};
   endfunction

   function automatic logic [NUM_M-1:0] model_gnt();
      return (m_own < 0) ? '0 : (NUM_M'(1) << m_own);
   endfunction

   task automatic model_reset();
      for (int k = 0; k < NUM_M; k++) m_list[k] = k;
      m_own  = -1;
      m_prev = 1'b1;
   endtask

   task automatic model_tick(input logic m, input logic hr,
                             input logic [NUM_EXT-1:0] er,
                             input logic fr, input logic ir);
      logic [NUM_M-1:0] rq;
      int   nxt, w, p;
      bit   st, drop, ev;
      rq[0] = hr;
      for (int i = 0; i < NUM_EXT; i++) rq[i+1] = ~er[i];
      nxt = -1;
      if (m) begin
         st   = m_prev && !fr && (m_own >= 0);
         drop = (m_own < 0) || !rq[m_own];
         ev   = (fr && ir) || drop;
         w    = 0;
         for (int k = NUM_M - 1; k >= 0; k--) if (rq[m_list[k]]) w = m_list[k];
         nxt = m_own;
         if (ev) begin
            if (m_own < 0)      nxt = w;
            else if (w != m_own) nxt = -1;
         end
         if (st) begin
            p = 0;
            for (int k = 0; k < NUM_M; k++) if (m_list[k] == m_own) p = k;
            for (int k = p; k < NUM_M - 1; k++) m_list[k] = m_list[k+1];
            m_list[NUM_M-1] = m_own;
         end
      end
      m_prev = fr;
      m_own  = nxt;
   endtask

   // Drive one cycle of inputs (called at a falling edge), then return at
   // the next falling edge with the registered outputs settled.
   task automatic step(input logic m, input logic hr,
                       input logic [NUM_EXT-1:0] er,
                       input logic fr, input logic ir);
      host_mode = m; host_req = hr; dev_req_n = er; frame_n = fr; irdy_n = ir;
      model_tick(m, hr, er, fr, ir);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input logic [NUM_M-1:0] got, input logic [NUM_M-1:0] exp,
                        input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: grants got=%b expected=%b at %0t", tag, got, exp, $time);
      end
   endtask

   // Table: {mode, host_req, dev_req_n[3:0], frame_n, irdy_n, expected grants}
   localparam int NVEC = 16;
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 4'b1111, 1'b1, 1'b1, 5'b00001},
      {1'b1, 1'b0, 4'b1101, 1'b1, 1'b1, 5'b00000},
      {1'b1, 1'b0, 4'b1101, 1'b1, 1'b1, 5'b00100},
      {1'b1, 1'b0, 4'b1101, 1'b0, 1'b1, 5'b00100},
      {1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, 5'b00000},
      {1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, 5'b00010},
      {1'b1, 1'b0, 4'b1010, 1'b1, 1'b1, 5'b00010},
      {1'b1, 1'b0, 4'b1010, 1'b0, 1'b1, 5'b00010},
      {1'b1, 1'b0, 4'b1011, 1'b0, 1'b0, 5'b00000},
      {1'b1, 1'b0, 4'b1011, 1'b0, 1'b0, 5'b01000},
      {1'b0, 1'b0, 4'b1011, 1'b1, 1'b1, 5'b00000},
      {1'b0, 1'b1, 4'b0000, 1'b0, 1'b0, 5'b00000},
      {1'b1, 1'b0, 4'b1111, 1'b1, 1'b1, 5'b00001},
      {1'b1, 1'b1, 4'b1111, 1'b0, 1'b1, 5'b00001},
      {1'b1, 1'b0, 4'b0000, 1'b1, 1'b1, 5'b00000},
      {1'b1, 1'b0, 4'b0000, 1'b1, 1'b1, 5'b01000}
   };

   function automatic string vec_tag(input int i);
      case (i)
         0, 12:  return "R4 park";
         1, 4:   return "R7 gap";
         2, 5:   return "R2 winner";
         3, 7:   return "R6 hold";
         6:      return "R6 idle same owner";
         8:      return "R3 moved to tail";
         9:      return "R3 order kept";
         10, 11: return "R8 non-host";
         13:     return "R5 host owner";
         default: return "R8 list frozen R3";
      endcase
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run hung, got=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [12:0] v;
      int dev4_hits;
      int mism;
      host_mode = 1'b1; host_req = 1'b0; dev_req_n = '1;
      frame_n = 1'b1; irdy_n = 1'b1;
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);

      // R1: outputs under reset
      check(got_gnt(), '0, "R1 reset grants");
      rst_n = 1'b1;

      // Table walk
      for (int i = 0; i < NVEC; i++) begin
         v = VEC[i];
         step(v[12], v[11], v[10:7], v[6], v[5]);
         check(got_gnt(), v[4:0], vec_tag(i));
      end

      // R1: list order restored by a mid-run reset
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      check(got_gnt(), '0, "R1 grants in reset");
      rst_n = 1'b1;
      step(1'b1, 1'b1, 4'b0000, 1'b1, 1'b1);
      check(got_gnt(), 5'b00001, "R1 host heads list");
      step(1'b1, 1'b0, 4'b0000, 1'b1, 1'b1);
      check(got_gnt(), 5'b00000, "R7 gap after reset");
      step(1'b1, 1'b0, 4'b0000, 1'b1, 1'b1);
      check(got_gnt(), 5'b00010, "R1 device 1 second");

      // R4: parked host stays while nobody requests
      step(1'b1, 1'b0, 4'b1111, 1'b1, 1'b1);
      step(1'b1, 1'b0, 4'b1111, 1'b1, 1'b1);
      step(1'b1, 1'b0, 4'b1111, 1'b1, 1'b1);
      check(got_gnt(), 5'b00001, "R4 park held");

      // Random run against the reference list model
      dev4_hits = 0;
      mism = 0;
      for (int c = 0; c < 6000; c++) begin
         logic m, hr, fr, ir;
         logic [NUM_EXT-1:0] er;
         m  = ($urandom_range(0, 24) != 0);
         hr = ($urandom_range(0, 3) == 0);
         for (int i = 0; i < NUM_EXT; i++) er[i] = ($urandom_range(0, 2) != 0);
         if (c < 3000) er[NUM_EXT-1] = 1'b1;
         if (c >= 5000 && c < 5200) begin hr = 1'b0; er = '1; end
         fr = ($urandom_range(0, 2) == 0);
         ir = ($urandom_range(0, 1) == 0);
         step(m, hr, er, fr, ir);
         if (c < 3000 && dev_gnt_n[NUM_EXT-1] == 1'b0) dev4_hits++;
         if (got_gnt() !== model_gnt()) begin
            mism++;
            if (mism <= 5) check(got_gnt(), model_gnt(), "R2 R3 R9 random vs model");
         end
      end
      check(mism == 0 ? 5'd0 : 5'd1, 5'd0, "R2 R3 R9 random run mismatches");
      check(5'(dev4_hits), 5'd0, "R10 unused device never granted");

      finish_run();
   end

endmodule